// File: doc/BRIEF.md
# Ten-Bit Sample Byte-Pair Framer

This block carries 10-bit samples, such as converter results, over a link that moves one byte at a time. The transmit half takes a sample through a valid/ready handshake and sends it as two bytes on consecutive cycles. Each byte says by itself whether it is the first or the second of its pair. Each byte also protects its own contents with two parity bits. No delimiter byte is needed.

The receive half takes bytes with a one-cycle valid strobe. It checks each byte on its own, pairs a first byte with the second byte that follows it, and produces the rebuilt sample as a one-cycle pulse. A damaged byte raises a parity flag. A byte that arrives out of turn raises a sequence flag. The receiver can start listening at any byte of a stream and locks on at the next good first byte. The two halves share only clock and reset. A link can feed the transmit output into the receive input, directly or through any byte-wide serial path.

Top module: `tbf_pair_framer`

## Requirements
- R1: A sample is split into a high half (bits 9..5) and a low half (bits 4..0). Bits 4..0 of the first byte hold the high half, and bits 4..0 of the second byte hold the low half, with the most significant bit at bit 4. Bit 5 is 0 in the first byte and 1 in the second.
- R2: In every byte, bit 7 is the XOR of bits 5, 4 and 3, and bit 6 is the XOR of bits 2, 1 and 0. A byte whose bits 7 or 6 disagree with these sums fails its check.
- R3: The sample 714 is sent as 0x96 and then 0x6A. When received, that byte pair yields 714.
- R4: `s_ready` is high whenever no second byte is waiting. A sample accepted on a clock edge appears as the first byte, with `tx_valid` high, in the following cycle. The second byte follows in the cycle after that. `s_ready` is low during the cycle the second byte is pending, and `tx_valid` is low in every cycle that carries no byte.
- R5: Take a received byte that passes its check with bit 5 at 0. If the next received byte also passes its check and has bit 5 at 1, then in the cycle after that second byte, `smp_valid` pulses high for exactly one cycle with `smp_data` equal to the rebuilt sample. Idle cycles between the two bytes do not break the pair.
- R6: Any received byte that fails its check, including any byte with one flipped bit, pulses `par_err` in the following cycle. That byte produces no sample and discards any stored first half.
- R7: A received second-position byte with good parity and no stored first half pulses `seq_err` in the following cycle and is dropped.
- R8: A good first-position byte that arrives while a first half is already stored pulses `seq_err` in the following cycle. The new high half replaces the old one.
- R9: After reset `s_ready` is high, and `tx_valid`, `smp_valid`, `par_err` and `seq_err` are low. At most one of `smp_valid`, `par_err` and `seq_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample offered on the transmit side |
| s_ready | output | 1 | Transmit side can accept a sample |
| s_data | input | 10 | Sample to transmit |
| tx_valid | output | 1 | `tx_byte` holds a byte to send this cycle |
| tx_byte | output | 8 | Outgoing framed byte |
| rx_valid | input | 1 | `rx_byte` holds a received byte this cycle |
| rx_byte | input | 8 | Incoming framed byte |
| smp_valid | output | 1 | One-cycle pulse: rebuilt sample is on `smp_data` |
| smp_data | output | 10 | Rebuilt sample |
| par_err | output | 1 | One-cycle pulse: last received byte failed its check |
| seq_err | output | 1 | One-cycle pulse: last received byte arrived out of order |

## Verification
The bench flips each of the eight bits of a good byte in turn. A receiver that checks only some bit positions would pass one of those flips through without a flag. It sends a good first byte, then a damaged byte, then a good second byte: a receiver that keeps the stored half across the damage would wrongly assemble a sample instead of flagging sequence. It also covers an orphan second byte, a repeated first byte whose newer half must win, a mid-stream start, and pairs split by idle gaps. A design that swapped halves, parity bits or the position bit would get the 714 example wrong on both the transmit and the receive side.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
    localparam int SAMPLE_W = 10;
    localparam int HALF_W   = SAMPLE_W / 2;
    localparam int BYTE_W   = HALF_W + 3;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [HALF_W-1:0]   half_t;
    typedef logic [BYTE_W-1:0]   byte_t;

    // Field layout of one link byte; order is fixed by the wire format.
    typedef struct packed {
        logic  par_hi;  // covers slot, data[4], data[3]
        logic  par_lo;  // covers data[2], data[1], data[0]
        logic  slot;    // 0 = carries high half, 1 = carries low half
        half_t data;
    } frame_t;

    function automatic frame_t build_frame(input logic slot, input half_t d);
        frame_t f;
        f.slot   = slot;
        f.data   = d;
        f.par_hi = slot ^ d[4] ^ d[3];
        f.par_lo = d[2] ^ d[1] ^ d[0];
        return f;
    endfunction

    function automatic logic frame_good(input frame_t f);
        return (f.par_hi == (f.slot ^ f.data[4] ^ f.data[3])) &&
               (f.par_lo == (f.data[2] ^ f.data[1] ^ f.data[0]));
    endfunction
endpackage

// File: rtl/tbf_tx.sv
module tbf_tx
    import tbf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    s_valid,
    output logic    s_ready,
    input  sample_t s_data,
    output logic    tx_valid,
    output byte_t   tx_byte
);
    logic   pend_q;
    half_t  low_q;
    frame_t out_q;
    logic   out_v_q;

    assign s_ready  = !pend_q;
    assign tx_valid = out_v_q;
    assign tx_byte  = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            low_q   <= '0;
            out_q   <= '0;
            out_v_q <= 1'b0;
        end else if (pend_q) begin
            out_q   <= build_frame(1'b1, low_q);
            out_v_q <= 1'b1;
            pend_q  <= 1'b0;
        end else if (s_valid) begin
            out_q   <= build_frame(1'b0, s_data[SAMPLE_W-1:HALF_W]);
            out_v_q <= 1'b1;
            low_q   <= s_data[HALF_W-1:0];
            pend_q  <= 1'b1;
        end else begin
            out_v_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tbf_rx.sv
module tbf_rx
    import tbf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rx_valid,
    input  byte_t   rx_byte,
    output logic    smp_valid,
    output sample_t smp_data,
    output logic    par_err,
    output logic    seq_err
);
    frame_t  in_f;
    logic    in_good;
    logic    have_hi_q;
    half_t   hi_q;
    logic    smp_v_q;
    sample_t smp_q;
    logic    perr_q;
    logic    serr_q;

    assign in_f    = frame_t'(rx_byte);
    assign in_good = frame_good(in_f);

    assign smp_valid = smp_v_q;
    assign smp_data  = smp_q;
    assign par_err   = perr_q;
    assign seq_err   = serr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_hi_q <= 1'b0;
            hi_q      <= '0;
            smp_v_q   <= 1'b0;
            smp_q     <= '0;
            perr_q    <= 1'b0;
            serr_q    <= 1'b0;
        end else begin
            smp_v_q <= 1'b0;
            perr_q  <= 1'b0;
            serr_q  <= 1'b0;
            if (rx_valid) begin
                if (!in_good) begin
                    perr_q    <= 1'b1;
                    have_hi_q <= 1'b0;
                end else if (!in_f.slot) begin
                    serr_q    <= have_hi_q;
                    hi_q      <= in_f.data;
                    have_hi_q <= 1'b1;
                end else if (have_hi_q) begin
                    smp_v_q   <= 1'b1;
                    smp_q     <= {hi_q, in_f.data};
                    have_hi_q <= 1'b0;
                end else begin
                    serr_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tbf_pair_framer.sv
module tbf_pair_framer
    import tbf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_data,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_byte,
    input  logic                rx_valid,
    input  logic [BYTE_W-1:0]   rx_byte,
    output logic                smp_valid,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic                par_err,
    output logic                seq_err
);
    tbf_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .s_valid  (s_valid),
        .s_ready  (s_ready),
        .s_data   (s_data),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    tbf_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .par_err   (par_err),
        .seq_err   (seq_err)
    );
endmodule

// File: rtl/tbf_pair_framer_chk.sv
module tbf_pair_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       s_valid,
    input logic       s_ready,
    input logic [9:0] s_data,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       smp_valid,
    input logic [9:0] smp_data,
    input logic       par_err,
    input logic       seq_err
);
    logic rx_bad;
    assign rx_bad = (rx_byte[7] != ^rx_byte[5:3]) || (rx_byte[6] != ^rx_byte[2:0]);

    // R4
    first_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> (tx_valid && !tx_byte[5] &&
                                  tx_byte[4:0] == $past(s_data[9:5])));
    // R4
    hold_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> !s_ready);
    // R4
    second_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_byte[5]) |=> (tx_valid && tx_byte[5]));
    // R2
    tx_parity_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_byte[7] == ^tx_byte[5:3] && tx_byte[6] == ^tx_byte[2:0]));
    // R6
    bad_byte_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_bad) |=> (par_err && !smp_valid));
    // R5
    sample_origin_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> ($past(rx_valid) && $past(rx_byte[5]) &&
                       smp_data[4:0] == $past(rx_byte[4:0])));
    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({smp_valid, par_err, seq_err}));
endmodule

bind tbf_pair_framer tbf_pair_framer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .par_err   (par_err),
    .seq_err   (seq_err)
);

// File: tb/tbf_pair_framer_tb_top.sv
module tbf_pair_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [9:0] s_data = '0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       smp_valid;
    logic [9:0] smp_data;
    logic       par_err;
    logic       seq_err;

    int checks = 0;
    int errors = 0;

    logic [7:0]  tx_exp_q[$];
    string       tx_tag_q[$];
    logic [11:0] rx_exp_q[$];   // {kind, value}: kind 1 sample, 2 parity, 3 sequence
    string       rx_tag_q[$];

    logic       m_have;
    logic [4:0] m_hi;

    always #5 clk = ~clk;

    tbf_pair_framer dut_i (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .par_err(par_err), .seq_err(seq_err)
    );

    function automatic logic [7:0] mk(input logic pos, input logic [4:0] d);
        return {pos ^ d[4] ^ d[3], d[2] ^ d[1] ^ d[0], pos, d};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Transmit driver: expected bytes come from the format rules (R1, R2, R4)
    task automatic send_sample(input logic [9:0] v, input string tag);
        tx_exp_q.push_back(mk(1'b0, v[9:5])); tx_tag_q.push_back(tag);
        tx_exp_q.push_back(mk(1'b1, v[4:0])); tx_tag_q.push_back(tag);
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        s_valid = 1'b1;
        s_data  = v;
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    // Receive driver with a reference model of R5..R8
    task automatic rx_put(input logic [7:0] b, input string tag);
        logic good;
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        good = (b[7] == (b[5] ^ b[4] ^ b[3])) && (b[6] == (b[2] ^ b[1] ^ b[0]));
        if (!good) begin
            rx_exp_q.push_back({2'd2, 10'd0}); rx_tag_q.push_back(tag);
            m_have = 1'b0;
        end else if (!b[5]) begin
            if (m_have) begin
                rx_exp_q.push_back({2'd3, 10'd0}); rx_tag_q.push_back(tag);
            end
            m_hi = b[4:0];
            m_have = 1'b1;
        end else if (m_have) begin
            rx_exp_q.push_back({2'd1, m_hi, b[4:0]}); rx_tag_q.push_back(tag);
            m_have = 1'b0;
        end else begin
            rx_exp_q.push_back({2'd3, 10'd0}); rx_tag_q.push_back(tag);
        end
    endtask

    task automatic rx_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
        end
    endtask

    // Monitors
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tx_valid) begin
                if (tx_exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected tx byte", tx_byte, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = tx_exp_q.pop_front();
                    t = tx_tag_q.pop_front();
                    check(tx_byte == e, t, "tx byte", tx_byte, e);
                end
            end
            if (!rst && (smp_valid || par_err || seq_err)) begin
                logic [11:0] got;
                got[11:10] = smp_valid ? 2'd1 : (par_err ? 2'd2 : 2'd3);
                got[9:0]   = smp_valid ? smp_data : 10'd0;
                if ((smp_valid + par_err + seq_err) > 1) got = 12'hfff;
                if (rx_exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected rx event", got, 0);
                end else begin
                    logic [11:0] e;
                    string t;
                    e = rx_exp_q.pop_front();
                    t = rx_tag_q.pop_front();
                    check(got == e, t, "rx event", got, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_have = 1'b0;
        m_hi   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(s_ready == 1'b1, "R9", "s_ready after reset", s_ready, 1);
        check({tx_valid, smp_valid, par_err, seq_err} == 4'b0, "R9", "outputs after reset",
              {tx_valid, smp_valid, par_err, seq_err}, 0);

        // R3 literal example on transmit
        tx_exp_q.push_back(8'h96); tx_tag_q.push_back("R3");
        tx_exp_q.push_back(8'h6A); tx_tag_q.push_back("R3");
        @(negedge clk);
        s_valid = 1'b1; s_data = 10'd714;
        @(negedge clk);
        s_valid = 1'b0;
        // R4 s_ready low while second byte pending (this negedge follows acceptance)
        check(s_ready == 1'b0, "R4", "s_ready while second byte pending", s_ready, 0);
        @(negedge clk);
        check(s_ready == 1'b1, "R4", "s_ready after second byte", s_ready, 1);

        // R1 R2 R4 several patterns
        send_sample(10'h000, "R1");
        send_sample(10'h3FF, "R2");
        send_sample(10'h2AA, "R1");
        send_sample(10'h155, "R2");
        send_sample(10'h21F, "R4");
        repeat (3) @(negedge clk);

        // R3 literal example on receive
        rx_put(8'h96, "R3");
        rx_put(8'h6A, "R3");
        rx_idle(2);
        // R5 normal pairs, including a gap between bytes
        rx_put(mk(1'b0, 5'h1F), "R5");
        rx_put(mk(1'b1, 5'h00), "R5");
        rx_put(mk(1'b0, 5'h05), "R5");
        rx_idle(3);
        rx_put(mk(1'b1, 5'h1A), "R5");
        rx_idle(2);
        // R7 orphan second byte, then mid-stream lock
        rx_put(mk(1'b1, 5'h11), "R7");
        rx_put(mk(1'b0, 5'h0C), "R5");
        rx_put(mk(1'b1, 5'h13), "R5");
        rx_idle(2);
        // R8 repeated first byte: newer half wins
        rx_put(mk(1'b0, 5'h01), "R8");
        rx_put(mk(1'b0, 5'h1E), "R8");
        rx_put(mk(1'b1, 5'h07), "R8");
        rx_idle(2);
        // R6 each single-bit flip of a good byte
        for (int i = 0; i < 8; i++) begin
            rx_put(8'h96 ^ (8'h01 << i), "R6");
        end
        rx_idle(2);
        // R6 damage between halves discards the stored half
        rx_put(mk(1'b0, 5'h09), "R6");
        rx_put(8'h6A ^ 8'h10, "R6");
        rx_put(mk(1'b1, 5'h0A), "R6");
        rx_idle(4);

        check(tx_exp_q.size() == 0, "R4", "tx bytes left unseen", tx_exp_q.size(), 0);
        check(rx_exp_q.size() == 0, "R5", "rx events left unseen", rx_exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule